// File: doc/BRIEF.md
# Holdover Frequency History Averager

This block keeps a sliding record of the frequency-control word produced by a clock-steering loop. One-second ticks are counted, and every few accepted ticks the current word is taken as a sample. Each sample enters a circular window that keeps a running sum. The mean over the samples held in the window is then computed and pushed into a short line of past averages. The entry that leaves the far end of that line becomes the holdover word. Because of this delay, the holdover word always lags the newest average by a fixed number of sample intervals. A late frequency-limit alarm therefore has time to stop a bad estimate before it reaches the holdover word.

Sampling pauses while either freeze input is high: loss of reference, or fast acquisition. A restart pulse marks a new reference. It empties the history, clears the holdover-good flag and starts qualification again. The last holdover word stays on the output, so a consumer entering holdover in that interval still has the previous qualified estimate. Words are unsigned.

The one-second tick must be spaced more than W + clog2(WIN+1) + 4 clock cycles apart. This gives the serial divider time to finish between samples.

Top module: `holdover_avg`

## Requirements
- R1: A sample is taken on every TPS-th accepted one-second tick, counted from reset or from the last restart. With TPS = 2, the 2nd, 4th, 6th and later accepted ticks each capture `freq_word`.
- R2: A tick that arrives while `los` or `fast_acq` is high is ignored. It takes no sample and does not advance the tick count, so the holdover outputs and the later sampling phase are exactly as if the tick had never occurred.
- R3: After sample n since restart, the average is the floor of the sum of the last min(n, WIN) samples divided by min(n, WIN).
- R4: At the average computed for sample n, `hold_word` takes the average that was computed for sample n - DLY, giving a lag of DLY sample intervals.
- R5: `hold_good` rises together with the first `hold_word` update after restart. That update carries an average formed once at least QUAL samples had been taken. `hold_good` then stays high until reset or restart.
- R6: `restart` clears `hold_good`, the window, the tick count and the delay line on the next clock edge, while `hold_word` keeps its last value.
- R7: `hold_vld` is a one-cycle pulse issued exactly when `hold_word` is loaded, and `hold_word` does not change at any other time. Only averages formed after qualification are loaded.
- R8: After reset, `hold_word` is 0 and both `hold_good` and `hold_vld` are 0.
- R9: Once WIN samples are held, each new sample replaces the oldest one, and the fill count never exceeds WIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle pulse once per second |
| freq_word | input | W | Frequency-control word from the loop |
| restart | input | 1 | One-cycle pulse on reference selection or switch |
| los | input | 1 | Loss of reference; freezes sampling |
| fast_acq | input | 1 | Fast acquisition active; freezes sampling |
| hold_word | output | W | Delayed, qualified average for holdover |
| hold_good | output | 1 | Holdover word is qualified since last restart |
| hold_vld | output | 1 | One-cycle strobe when hold_word is loaded |

## Verification
A series of rising words checks that the first QUAL samples after restart stay hidden, and that the delayed output lags by exactly DLY intervals. Words near full scale go past the window length, which shows the oldest sample being dropped and the running sum holding its width. Ticks placed under each freeze input show whether the tick phase stalls or slips: each would leave a different output sequence afterwards. A restart in mid-stream separates clearing the flag from clearing the word, and fresh words after it confirm that qualification starts again from zero.

// File: rtl/holdover_pkg.sv
package holdover_pkg;

   typedef struct packed {
      logic valid;
      logic qual;
   } hist_tag_t;

   function automatic int sum_width(input int word_w, input int depth);
      return word_w + $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/holdover_tick_gate.sv
module holdover_tick_gate #(
   parameter int TPS = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic sec_tick,
   input  logic restart,
   input  logic freeze,
   output logic take
);
   localparam int TCW = (TPS > 1) ? $clog2(TPS) : 1;
   localparam logic [TCW-1:0] LAST = TCW'(TPS - 1);

   logic [TCW-1:0] cnt;

   assign take = sec_tick && !freeze && !restart && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         cnt <= '0;
      end else if (sec_tick && !freeze) begin
         cnt <= (cnt == LAST) ? '0 : cnt + TCW'(1);
      end
   end

   p_freeze_hold_r2 : assert property (@(posedge clk) disable iff (rst)
      (freeze && !restart) |=> $stable(cnt));

   p_cnt_range_r1 : assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST);

endmodule

// File: rtl/holdover_window.sv
module holdover_window #(
   parameter int W    = 24,
   parameter int WIN  = 131,
   parameter int QUAL = 88,
   parameter int SUMW = holdover_pkg::sum_width(W, WIN),
   parameter int CW   = $clog2(WIN + 1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            restart,
   input  logic            take,
   input  logic [W-1:0]    word,
   output logic            start,
   output logic [SUMW-1:0] sum_q,
   output logic [CW-1:0]   fill_q,
   output logic            qual_q
);
   localparam int PW  = $clog2(WIN);
   localparam int QCW = $clog2(QUAL + 1);

   logic [W-1:0]   mem [WIN];
   logic [PW-1:0]  ptr;
   logic [QCW-1:0] qcnt;
   logic [W-1:0]   oldest;
   logic [QCW-1:0] qcnt_nx;
   logic           full;

   assign full    = (fill_q == CW'(WIN));
   assign oldest  = full ? mem[ptr] : '0;
   assign qcnt_nx = (qcnt == QCW'(QUAL)) ? qcnt : qcnt + QCW'(1);

   always_ff @(posedge clk) begin
      if (take) begin
         mem[ptr] <= word;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         ptr    <= '0;
         fill_q <= '0;
         sum_q  <= '0;
         qcnt   <= '0;
         start  <= 1'b0;
         qual_q <= 1'b0;
      end else begin
         start <= take;
         if (take) begin
            ptr    <= (ptr == PW'(WIN - 1)) ? '0 : ptr + PW'(1);
            fill_q <= full ? fill_q : fill_q + CW'(1);
            sum_q  <= sum_q - SUMW'(oldest) + SUMW'(word);
            qcnt   <= qcnt_nx;
            qual_q <= (qcnt_nx == QCW'(QUAL));
         end
      end
   end

   p_fill_bound_r9 : assert property (@(posedge clk) disable iff (rst)
      fill_q <= CW'(WIN));

   p_start_after_take_r3 : assert property (@(posedge clk) disable iff (rst)
      (take && !restart) |=> (start && fill_q != '0));

endmodule

// File: rtl/holdover_divider.sv
module holdover_divider #(
   parameter int NW = 32,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          restart,
   input  logic          start,
   input  logic [NW-1:0] num,
   input  logic [DW-1:0] den,
   output logic          done,
   output logic [NW-1:0] quot
);
   localparam int CNTW = $clog2(NW + 1);

   logic [NW-1:0]   acc;
   logic [DW-1:0]   rem;
   logic [DW-1:0]   dv;
   logic [CNTW-1:0] left;
   logic            busy;
   logic [DW:0]     rem_sh;
   logic [DW:0]     rem_sub;
   logic            ge;

   always_comb begin
      rem_sh  = {rem, acc[NW-1]};
      ge      = (rem_sh >= {1'b0, dv});
      rem_sub = rem_sh - {1'b0, dv};
   end

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         acc  <= '0;
         rem  <= '0;
         dv   <= '0;
         left <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            acc  <= num;
            dv   <= den;
            rem  <= '0;
            left <= CNTW'(NW);
            busy <= 1'b1;
         end else if (busy) begin
            acc  <= {acc[NW-2:0], ge};
            rem  <= ge ? rem_sub[DW-1:0] : rem_sh[DW-1:0];
            left <= left - CNTW'(1);
            if (left == CNTW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign quot = acc;

   p_den_nonzero_r3 : assert property (@(posedge clk) disable iff (rst)
      start |-> (den != '0));

   p_done_single_r7 : assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

endmodule

// File: rtl/holdover_delay.sv
module holdover_delay #(
   parameter int W   = 24,
   parameter int DLY = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         restart,
   input  logic         tag_load,
   input  logic         tag_qual,
   input  logic         push,
   input  logic [W-1:0] push_word,
   output logic [W-1:0] hold_word,
   output logic         hold_good,
   output logic         hold_vld
);
   import holdover_pkg::*;

   logic [W-1:0] data [DLY];
   hist_tag_t    tag  [DLY];
   logic         pend_qual;
   logic         tail_ok;

   assign tail_ok = tag[DLY-1].valid && tag[DLY-1].qual;

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         pend_qual <= 1'b0;
      end else if (tag_load) begin
         pend_qual <= tag_qual;
      end
   end

   for (genvar i = 0; i < DLY; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst || restart) begin
            data[i] <= '0;
            tag[i]  <= '0;
         end else if (push) begin
            if (i == 0) begin
               data[i] <= push_word;
               tag[i]  <= '{valid: 1'b1, qual: pend_qual};
            end else begin
               data[i] <= data[i-1];
               tag[i]  <= tag[i-1];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_word <= '0;
         hold_good <= 1'b0;
         hold_vld  <= 1'b0;
      end else if (restart) begin
         hold_good <= 1'b0;
         hold_vld  <= 1'b0;
      end else begin
         hold_vld <= push && tail_ok;
         if (push && tail_ok) begin
            hold_word <= data[DLY-1];
            hold_good <= 1'b1;
         end
      end
   end

   p_word_moves_with_vld_r7 : assert property (@(posedge clk) disable iff (rst)
      !$stable(hold_word) |-> hold_vld);

   p_vld_single_r7 : assert property (@(posedge clk) disable iff (rst)
      hold_vld |=> !hold_vld);

   p_good_rises_on_vld_r5 : assert property (@(posedge clk) disable iff (rst)
      $rose(hold_good) |-> hold_vld);

   p_restart_clears_r6 : assert property (@(posedge clk) disable iff (rst)
      restart |=> (!hold_good && $stable(hold_word)));

endmodule

// File: rtl/holdover_avg.sv
module holdover_avg #(
   parameter int W    = 24,
   parameter int TPS  = 8,
   parameter int WIN  = 131,
   parameter int QUAL = 88,
   parameter int DLY  = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         sec_tick,
   input  logic [W-1:0] freq_word,
   input  logic         restart,
   input  logic         los,
   input  logic         fast_acq,
   output logic [W-1:0] hold_word,
   output logic         hold_good,
   output logic         hold_vld
);
   localparam int SUMW = holdover_pkg::sum_width(W, WIN);
   localparam int CW   = $clog2(WIN + 1);

   if (W < 2)     begin : g_chk_w    $error("holdover_avg: W must be at least 2");    end
   if (TPS < 2)   begin : g_chk_tps  $error("holdover_avg: TPS must be at least 2");  end
   if (WIN < 2)   begin : g_chk_win  $error("holdover_avg: WIN must be at least 2");  end
   if (QUAL < 1)  begin : g_chk_qual $error("holdover_avg: QUAL must be at least 1"); end
   if (DLY < 1)   begin : g_chk_dly  $error("holdover_avg: DLY must be at least 1");  end

   logic            freeze;
   logic            take;
   logic            start;
   logic [SUMW-1:0] sum_q;
   logic [CW-1:0]   fill_q;
   logic            qual_q;
   logic            done;
   logic [SUMW-1:0] quot;

   assign freeze = los || fast_acq;

   holdover_tick_gate #(.TPS(TPS)) u_tick (
      .clk(clk), .rst(rst), .sec_tick(sec_tick), .restart(restart),
      .freeze(freeze), .take(take)
   );

   holdover_window #(.W(W), .WIN(WIN), .QUAL(QUAL), .SUMW(SUMW), .CW(CW)) u_win (
      .clk(clk), .rst(rst), .restart(restart), .take(take), .word(freq_word),
      .start(start), .sum_q(sum_q), .fill_q(fill_q), .qual_q(qual_q)
   );

   holdover_divider #(.NW(SUMW), .DW(CW)) u_div (
      .clk(clk), .rst(rst), .restart(restart), .start(start),
      .num(sum_q), .den(fill_q), .done(done), .quot(quot)
   );

   holdover_delay #(.W(W), .DLY(DLY)) u_dly (
      .clk(clk), .rst(rst), .restart(restart),
      .tag_load(start), .tag_qual(qual_q),
      .push(done), .push_word(quot[W-1:0]),
      .hold_word(hold_word), .hold_good(hold_good), .hold_vld(hold_vld)
   );

   p_reset_quiet_r8 : assert property (@(posedge clk)
      rst |=> (!hold_vld && !hold_good && hold_word == '0));

endmodule

// File: tb/holdover_avg_test.sv
`timescale 1ns/1ps
module holdover_avg_test;
   localparam int W = 16, TPS = 2, WIN = 4, QUAL = 3, DLY = 2;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         sec_tick = 1'b0;
   logic [W-1:0] freq_word = '0;
   logic         restart = 1'b0;
   logic         los = 1'b0;
   logic         fast_acq = 1'b0;
   logic [W-1:0] hold_word;
   logic         hold_good;
   logic         hold_vld;

   int checks = 0;
   int errors = 0;
   int vld_seen = 0;

   int tick_cnt = 0;
   int n = 0;
   longint samp [0:255];
   longint avg  [0:255];
   logic [W-1:0] exp_word = '0;
   logic         exp_good = 1'b0;
   int           exp_vld  = 0;

   always #2.5 clk = ~clk;

   holdover_avg #(.W(W), .TPS(TPS), .WIN(WIN), .QUAL(QUAL), .DLY(DLY)) uut (
      .clk(clk), .rst(rst), .sec_tick(sec_tick), .freq_word(freq_word),
      .restart(restart), .los(los), .fast_acq(fast_acq),
      .hold_word(hold_word), .hold_good(hold_good), .hold_vld(hold_vld)
   );

   always @(posedge clk) if (!rst && hold_vld) vld_seen++;

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_outputs(input string req);
      check(req, "hold_word", hold_word, exp_word);
      check(req, "hold_good", hold_good, exp_good);
      check(req, "strobe count", vld_seen, exp_vld);
   endtask

   // One tick with optional freeze; model per R1/R2/R3/R4/R5/R9, then check.
   task automatic step(input logic [W-1:0] w, input logic l, input logic f, input string req);
      @(negedge clk);
      freq_word = w; los = l; fast_acq = f; sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      repeat (40) @(negedge clk);
      los = 1'b0; fast_acq = 1'b0;
      if (!(l || f)) begin
         tick_cnt++;
         if (tick_cnt == TPS) begin
            longint s = 0;
            int lo;
            tick_cnt = 0;
            n++;
            samp[n] = w;
            lo = (n > WIN) ? n - WIN + 1 : 1;
            for (int k = lo; k <= n; k++) s += samp[k];
            avg[n] = s / (n - lo + 1);
            if (n - DLY >= QUAL) begin
               exp_word = avg[n-DLY][W-1:0];
               exp_good = 1'b1;
               exp_vld++;
            end
         end
      end
      check_outputs(req);
   endtask

   task automatic t_reset;
      check("R8", "reset hold_word", hold_word, 0);
      check("R8", "reset hold_good", hold_good, 0);
      check("R8", "reset hold_vld", hold_vld, 0);
   endtask

   task automatic t_fill;
      // R1 R3 R4 R5 R7: rising words through qualification
      for (int i = 0; i < 10; i++) step(16'(1000 + 37 * i), 1'b0, 1'b0, "R1/R3/R4/R5/R7");
      // R9: near-full-scale words beyond the window length
      for (int i = 0; i < 12; i++) step(16'hFFF0 - 16'(i * 5), 1'b0, 1'b0, "R9/R3");
   endtask

   task automatic t_freeze;
      // R2: an odd number of frozen ticks must not shift the sampling phase
      step(16'd500, 1'b0, 1'b0, "R2");
      step(16'd9, 1'b1, 1'b0, "R2 los");
      step(16'd9, 1'b0, 1'b1, "R2 fast_acq");
      step(16'd9, 1'b1, 1'b1, "R2 both");
      step(16'd700, 1'b0, 1'b0, "R2");
      step(16'd800, 1'b0, 1'b0, "R2");
      step(16'd900, 1'b0, 1'b0, "R2");
   endtask

   task automatic t_restart;
      step(16'd1234, 1'b0, 1'b0, "R6");
      @(negedge clk);
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      tick_cnt = 0; n = 0; exp_good = 1'b0;
      repeat (3) @(negedge clk);
      check_outputs("R6");
      for (int i = 0; i < 8; i++) step(16'(200 + 11 * i), 1'b0, 1'b0, "R6/R5");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_fill();
      t_freeze();
      t_restart();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule